// File: doc/BRIEF.md
# Sub-word write coalescing bridge

The bridge connects a host port that issues byte, halfword and word register accesses to a register file that only takes aligned 32-bit reads and writes. A narrow read becomes one aligned 32-bit read, and the addressed lane is then shifted down and masked. A narrow write becomes a read-modify-write of the containing word. A word write goes straight through.

Halfword writes to the block-size, block-count and transfer-mode fields are not sent on. They are merged into two 32-bit shadow words. A halfword write to the command field flushes them: the block word goes out first if it holds anything, then the transfer-mode/command word. Each shadow word reaches the register file as a single 32-bit write. Two writes to the same register therefore never arrive close together.

After every downstream write, the bridge holds off further traffic when the card clock is slow. The hold is four card-clock periods rounded up to whole microseconds, measured on a microsecond tick. The card clock rate is a plain input. The bridge recomputes the microsecond count with a serial divider whenever that rate changes.

Top module: `rcb_bridge`

## Requirements
- R1: A byte or halfword read issues one downstream read at the address with bits [1:0] cleared. It returns the word shifted right by 8 times address bits [1:0] and masked to 8 or 16 bits. `rd_valid` pulses two clock edges after the request is accepted. Size codes are 0 byte, 1 halfword and 2 word.
- R2: A word read returns the whole aligned word. A word write produces exactly one downstream write of the unchanged data to the aligned address.
- R3: A byte write reads the containing word, replaces the addressed byte lane and writes the word back in one downstream write.
- R4: A halfword write to offset 0x04 or 0x06 merges into the block shadow word and causes no downstream read or write.
- R5: A halfword write to offset 0x0C merges into the command shadow word and causes no downstream read or write.
- R6: A halfword write to offset 0x0E first writes the block shadow to 0x04, but only when that shadow is nonzero, and then clears it. It then writes {command halfword, command shadow [15:0]} to 0x0C. The command shadow keeps its transfer-mode bits.
- R7: A halfword write to any other offset is a read-modify-write of the containing word that replaces only the addressed 16-bit lane.
- R8: After each downstream write, `up_ready` stays low for a number of microsecond ticks. That number is ceil(4,000,000 / `card_clk_hz`) for a rate from 1 to 400,000 Hz, 10 for a rate of 0, and none above 400,000 Hz.
- R9: After reset both shadow words are zero, `up_ready` is high and `rd_valid`, `dn_rd` and `dn_wr` are low.
- R10: `up_ready` is low while a downstream cycle, a hold-off or a recomputation after a rate change is in progress. `dn_rd` and `dn_wr` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| up_valid | input | 1 | Host request present |
| up_ready | output | 1 | Bridge can take a request |
| up_write | input | 1 | 1 write, 0 read |
| up_size | input | 2 | 0 byte, 1 halfword, 2 word |
| up_addr | input | AW | Byte offset of the access |
| up_wdata | input | DW | Write value, right-aligned |
| rd_valid | output | 1 | Read result strobe |
| rd_data | output | DW | Read result, right-aligned |
| dn_rd | output | 1 | Downstream read strobe |
| dn_wr | output | 1 | Downstream write strobe |
| dn_addr | output | AW | Downstream word address |
| dn_wdata | output | DW | Downstream write word |
| dn_rdata | input | DW | Downstream read word, valid the cycle after `dn_rd` |
| card_clk_hz | input | CW | Configured card clock in Hz |
| us_tick | input | 1 | One-cycle pulse per microsecond |

## Verification
Every result of the bridge falls due a fixed number of edges after acceptance:
- Read data arrives on the second edge after acceptance.
- A word or command write reaches the register file on the first edge, and a read-modify-write reaches it on the third.
- A shadowed write leaves the downstream port idle and `up_ready` high.
- A hold-off releases on the edge of its last counted tick.

The bench drives on falling edges and samples there. It counts falling edges from acceptance to fix read latency exactly. It counts ticks only in cycles with no downstream strobe, so the measured hold equals the computed microsecond count.

// File: rtl/rcb_pkg.sv
`timescale 1ns/1ps
package rcb_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } acc_size_e;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_RD    = 3'd1,
        ST_RCAP  = 3'd2,
        ST_WBLK  = 3'd3,
        ST_WMAIN = 3'd4,
        ST_HOLD  = 3'd5
    } br_state_e;

    // halfword offsets that steer coalescing
    localparam int unsigned OFF_BLK_SIZE  = 4;
    localparam int unsigned OFF_BLK_COUNT = 6;
    localparam int unsigned OFF_XFER_MODE = 12;
    localparam int unsigned OFF_COMMAND   = 14;

endpackage

// File: rtl/rcb_lane_get.sv
`timescale 1ns/1ps
module rcb_lane_get #(
    parameter int DW = 32,
    localparam int LW = $clog2(DW / 8)
) (
    input  logic [DW-1:0] word_in,
    input  logic [LW-1:0] lane,
    input  logic [1:0]    size,
    output logic [DW-1:0] value
);
    import rcb_pkg::*;

    logic [LW+2:0]  shift_bits;
    logic [DW-1:0]  keep;

    always_comb begin
        shift_bits = {lane, 3'b000};
        case (size)
            SZ_BYTE: keep = {{(DW-8){1'b0}}, 8'hFF};
            SZ_HALF: keep = {{(DW-16){1'b0}}, 16'hFFFF};
            default: keep = '1;
        endcase
        value = (word_in >> shift_bits) & keep;
    end
endmodule

// File: rtl/rcb_lane_put.sv
`timescale 1ns/1ps
module rcb_lane_put #(
    parameter int DW = 32,
    localparam int LW = $clog2(DW / 8)
) (
    input  logic [DW-1:0] base_word,
    input  logic [LW-1:0] lane,
    input  logic [1:0]    size,
    input  logic [DW-1:0] new_val,
    output logic [DW-1:0] merged
);
    import rcb_pkg::*;

    logic [LW+2:0] shift_bits;
    logic [DW-1:0] keep;

    always_comb begin
        shift_bits = {lane, 3'b000};
        case (size)
            SZ_BYTE: keep = {{(DW-8){1'b0}}, 8'hFF};
            SZ_HALF: keep = {{(DW-16){1'b0}}, 16'hFFFF};
            default: keep = '1;
        endcase
        merged = (base_word & ~(keep << shift_bits)) | ((new_val & keep) << shift_bits);
    end
endmodule

// File: rtl/rcb_holdoff.sv
`timescale 1ns/1ps
module rcb_holdoff #(
    parameter int CW      = 32,
    parameter int LOW_HZ  = 400000,
    parameter int PERIODS = 4,
    parameter int ZERO_US = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] card_clk_hz,
    output logic [CW-1:0] hold_us,
    output logic          busy
);
    localparam int SW = $clog2(CW + 1);
    localparam logic [CW-1:0] NUM_US  = CW'(PERIODS * 1000000);
    localparam logic [CW-1:0] LOW_LIM = CW'(LOW_HZ);
    localparam logic [CW-1:0] IDLE_US = CW'(ZERO_US);

    typedef struct packed {
        logic [CW-1:0] seen;
        logic          run;
        logic [SW-1:0] step;
        logic [CW:0]   rem;
        logic [CW-1:0] quo;
        logic [CW-1:0] den;
        logic [CW-1:0] hold;
    } hs_t;

    hs_t q, d;
    logic [CW:0] rem_sh;

    // serial restoring divide: ceil(NUM_US / rate)
    always_comb begin
        d      = q;
        rem_sh = '0;
        if (q.run) begin
            rem_sh = {q.rem[CW-1:0], q.quo[CW-1]};
            d.quo  = {q.quo[CW-2:0], 1'b0};
            if (rem_sh >= {1'b0, q.den}) begin
                d.rem    = rem_sh - {1'b0, q.den};
                d.quo[0] = 1'b1;
            end else begin
                d.rem = rem_sh;
            end
            d.step = q.step - 1'b1;
            if (q.step == SW'(1)) begin
                d.run  = 1'b0;
                d.hold = d.quo;
            end
        end else if (card_clk_hz != q.seen) begin
            d.seen = card_clk_hz;
            if (card_clk_hz == '0) begin
                d.hold = IDLE_US;
            end else if (card_clk_hz > LOW_LIM) begin
                d.hold = '0;
            end else begin
                d.run  = 1'b1;
                d.step = SW'(CW);
                d.rem  = '0;
                d.quo  = NUM_US + card_clk_hz - 1'b1;
                d.den  = card_clk_hz;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.hold <= IDLE_US;
        end else begin
            q <= d;
        end
    end

    assign hold_us = q.hold;
    assign busy    = q.run || (card_clk_hz != q.seen);

    assert_fast_no_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && card_clk_hz > LOW_LIM) |-> hold_us == '0);
    assert_stopped_clock_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && card_clk_hz == '0) |-> hold_us == IDLE_US);
    assert_slow_nonzero_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && card_clk_hz != '0 && card_clk_hz <= LOW_LIM) |-> hold_us != '0);
endmodule

// File: rtl/rcb_bridge.sv
`timescale 1ns/1ps
module rcb_bridge #(
    parameter int AW      = 8,
    parameter int DW      = 32,
    parameter int CW      = 32,
    parameter int LOW_HZ  = 400000,
    parameter int PERIODS = 4,
    parameter int ZERO_US = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          up_valid,
    output logic          up_ready,
    input  logic          up_write,
    input  logic [1:0]    up_size,
    input  logic [AW-1:0] up_addr,
    input  logic [DW-1:0] up_wdata,
    output logic          rd_valid,
    output logic [DW-1:0] rd_data,
    output logic          dn_rd,
    output logic          dn_wr,
    output logic [AW-1:0] dn_addr,
    output logic [DW-1:0] dn_wdata,
    input  logic [DW-1:0] dn_rdata,
    input  logic [CW-1:0] card_clk_hz,
    input  logic          us_tick
);
    import rcb_pkg::*;

    localparam int LW = $clog2(DW / 8);
    localparam logic [AW-1:0] A_BSIZE = AW'(OFF_BLK_SIZE);
    localparam logic [AW-1:0] A_BCNT  = AW'(OFF_BLK_COUNT);
    localparam logic [AW-1:0] A_XFER  = AW'(OFF_XFER_MODE);
    localparam logic [AW-1:0] A_CMD   = AW'(OFF_COMMAND);
    localparam logic [AW-1:0] A_BLKW  = AW'(OFF_BLK_SIZE) & ~AW'((1 << LW) - 1);

    typedef struct packed {
        br_state_e     st;
        logic [AW-1:0] addr;
        logic [1:0]    size;
        logic          write;
        logic [DW-1:0] wdata;
        logic [DW-1:0] out_word;
        logic [DW-1:0] blk_sh;
        logic [DW-1:0] cmd_sh;
        logic [DW-1:0] rd_data;
        logic          rd_valid;
        logic          pend;
        logic [CW-1:0] cnt;
    } br_t;

    br_t q, d;

    logic [CW-1:0] hold_us;
    logic          hold_busy;
    logic          accept;
    logic          is_blk, is_xfer, is_cmd, is_half;
    logic [DW-1:0] sh_base, sh_merged, rd_merged, rd_lane;

    assign accept  = up_valid && up_ready;
    assign is_half = (up_size == SZ_HALF);
    assign is_blk  = (up_addr == A_BSIZE) || (up_addr == A_BCNT);
    assign is_xfer = (up_addr == A_XFER);
    assign is_cmd  = (up_addr == A_CMD);
    assign sh_base = is_blk ? q.blk_sh : q.cmd_sh;

    rcb_holdoff #(.CW(CW), .LOW_HZ(LOW_HZ), .PERIODS(PERIODS), .ZERO_US(ZERO_US)) u_hold (
        .clk(clk), .rst_n(rst_n), .card_clk_hz(card_clk_hz),
        .hold_us(hold_us), .busy(hold_busy)
    );

    rcb_lane_put #(.DW(DW)) u_shadow_put (
        .base_word(sh_base), .lane(up_addr[LW-1:0]), .size(up_size),
        .new_val(up_wdata), .merged(sh_merged)
    );

    rcb_lane_put #(.DW(DW)) u_rmw_put (
        .base_word(dn_rdata), .lane(q.addr[LW-1:0]), .size(q.size),
        .new_val(q.wdata), .merged(rd_merged)
    );

    rcb_lane_get #(.DW(DW)) u_rd_get (
        .word_in(dn_rdata), .lane(q.addr[LW-1:0]), .size(q.size), .value(rd_lane)
    );

    always_comb begin
        d          = q;
        d.rd_valid = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (accept) begin
                    d.addr  = up_addr;
                    d.size  = up_size;
                    d.write = up_write;
                    d.wdata = up_wdata;
                    if (!up_write) begin
                        d.st = ST_RD;
                    end else if (up_size != SZ_BYTE && !is_half) begin
                        d.out_word = up_wdata;
                        d.st       = ST_WMAIN;
                    end else if (is_half && is_blk) begin
                        d.blk_sh = sh_merged;
                    end else if (is_half && is_xfer) begin
                        d.cmd_sh = sh_merged;
                    end else if (is_half && is_cmd) begin
                        d.out_word = sh_merged;
                        d.st       = (q.blk_sh != '0) ? ST_WBLK : ST_WMAIN;
                    end else begin
                        d.st = ST_RD;
                    end
                end
            end
            ST_RD: d.st = ST_RCAP;
            ST_RCAP: begin
                if (q.write) begin
                    d.out_word = rd_merged;
                    d.st       = ST_WMAIN;
                end else begin
                    d.rd_valid = 1'b1;
                    d.rd_data  = rd_lane;
                    d.st       = ST_IDLE;
                end
            end
            ST_WBLK: begin
                d.blk_sh = '0;
                d.pend   = 1'b1;
                if (hold_us != '0) begin
                    d.cnt = hold_us;
                    d.st  = ST_HOLD;
                end else begin
                    d.st = ST_WMAIN;
                end
            end
            ST_WMAIN: begin
                d.pend = 1'b0;
                if (hold_us != '0) begin
                    d.cnt = hold_us;
                    d.st  = ST_HOLD;
                end else begin
                    d.st = ST_IDLE;
                end
            end
            ST_HOLD: begin
                if (us_tick) begin
                    if (q.cnt <= CW'(1)) d.st = q.pend ? ST_WMAIN : ST_IDLE;
                    else                 d.cnt = q.cnt - 1'b1;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign up_ready = (q.st == ST_IDLE) && !hold_busy;
    assign rd_valid = q.rd_valid;
    assign rd_data  = q.rd_data;
    assign dn_rd    = (q.st == ST_RD);
    assign dn_wr    = (q.st == ST_WBLK) || (q.st == ST_WMAIN);
    assign dn_addr  = (q.st == ST_WBLK) ? A_BLKW : {q.addr[AW-1:LW], {LW{1'b0}}};
    assign dn_wdata = (q.st == ST_WBLK) ? q.blk_sh : q.out_word;

    assert_rd_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(dn_rd, 2));
    assert_byte_write_reads_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && up_write && up_size == SZ_BYTE) |=> dn_rd);
    assert_blk_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && up_write && is_half && is_blk) |=> (!dn_wr && !dn_rd));
    assert_xfer_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && up_write && is_half && is_xfer) |=> (!dn_wr && !dn_rd));
    assert_cmd_flush_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && up_write && is_half && is_cmd) |=> (dn_wr && (dn_addr == A_BLKW || dn_addr == (A_XFER & ~AW'((1 << LW) - 1)))));
    assert_strobes_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(dn_rd && dn_wr));
    assert_ready_idle_down_R10: assert property (@(posedge clk) disable iff (!rst_n)
        up_ready |-> (!dn_rd && !dn_wr));
endmodule

// File: tb/tb_rcb_bridge.sv
`timescale 1ns/1ps
module tb_rcb_bridge;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        up_valid = 1'b0, up_write = 1'b0;
    logic [1:0]  up_size = 2'd0;
    logic [7:0]  up_addr = 8'd0;
    logic [31:0] up_wdata = 32'd0;
    logic        up_ready, rd_valid, dn_rd, dn_wr;
    logic [31:0] rd_data, dn_wdata;
    logic [31:0] dn_rdata = 32'd0;
    logic [7:0]  dn_addr;
    logic [31:0] card_clk_hz = 32'd0;
    logic        us_tick;
    logic [1:0]  tc = 2'd0;

    int nchk = 0, nfail = 0, nwr = 0, cyc = 0;
    bit done = 1'b0;
    logic [31:0] mem [64];
    logic [7:0]  log_a [16];
    logic [31:0] log_d [16];

    always #2.5 clk = ~clk;

    rcb_bridge dut (
        .clk(clk), .rst_n(rst_n), .up_valid(up_valid), .up_ready(up_ready),
        .up_write(up_write), .up_size(up_size), .up_addr(up_addr), .up_wdata(up_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data), .dn_rd(dn_rd), .dn_wr(dn_wr),
        .dn_addr(dn_addr), .dn_wdata(dn_wdata), .dn_rdata(dn_rdata),
        .card_clk_hz(card_clk_hz), .us_tick(us_tick)
    );

    // downstream register file model and write log
    initial for (int i = 0; i < 64; i++)
        mem[i] = {8'(i + 8'h40), 8'(i + 8'h30), 8'(i + 8'h20), 8'(i + 8'h10)};

    always @(posedge clk) begin
        if (dn_rd) dn_rdata <= mem[dn_addr[7:2]];
        if (dn_wr) begin
            mem[dn_addr[7:2]] <= dn_wdata;
            log_a[nwr % 16]   <= dn_addr;
            log_d[nwr % 16]   <= dn_wdata;
            nwr               <= nwr + 1;
        end
        tc <= tc + 2'd1;
    end
    assign us_tick = (tc == 2'd3);

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            nfail++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            summary();
            $finish;
        end
    end

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %h expected %h", rq, act, exp);
        end
    endtask

    task automatic do_op(input logic we, input logic [1:0] sz, input logic [7:0] ad,
                         input logic [31:0] wd, output logic [31:0] rdat,
                         output int lat, output int ticks, output int nw);
        int base;
        int guard = 0;
        while (!up_ready && guard < 5000) begin @(negedge clk); guard++; end
        base = nwr;
        up_valid = 1'b1; up_write = we; up_size = sz; up_addr = ad; up_wdata = wd;
        @(negedge clk);
        up_valid = 1'b0;
        lat = 0; ticks = 0; rdat = '0;
        if (!we) begin
            while (!rd_valid && lat < 100) begin @(negedge clk); lat++; end
            rdat = rd_data;
        end else begin
            guard = 0;
            while (!up_ready && guard < 100000) begin
                if (!dn_wr && !dn_rd && us_tick) ticks++;
                @(negedge clk);
                guard++;
            end
        end
        nw = nwr - base;
    endtask

    task automatic set_rate(input logic [31:0] hz);
        int guard = 0;
        card_clk_hz = hz;
        @(negedge clk);
        while (!up_ready && guard < 1000) begin @(negedge clk); guard++; end
    endtask

    typedef struct packed {
        logic        we;
        logic [1:0]  sz;
        logic [7:0]  addr;
        logic [31:0] data;
        logic [1:0]  nw;
        logic [7:0]  eaddr;
        logic [31:0] eval;
        logic [3:0]  rq;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 2'd2, 8'h20, 32'h0,        2'd0, 8'h00, 32'h48382818, 4'd2},  // R2 word read
        '{1'b0, 2'd0, 8'h21, 32'h0,        2'd0, 8'h00, 32'h00000028, 4'd1},  // R1 byte lane 1
        '{1'b0, 2'd1, 8'h22, 32'h0,        2'd0, 8'h00, 32'h00004838, 4'd1},  // R1 upper half
        '{1'b0, 2'd0, 8'h23, 32'h0,        2'd0, 8'h00, 32'h00000048, 4'd1},  // R1 byte lane 3
        '{1'b1, 2'd0, 8'h31, 32'h000000AB, 2'd1, 8'h30, 32'h4C3CAB1C, 4'd3},  // R3
        '{1'b1, 2'd1, 8'h42, 32'h0000BEEF, 2'd1, 8'h40, 32'hBEEF3020, 4'd7},  // R7
        '{1'b1, 2'd2, 8'h44, 32'hDEADBEEF, 2'd1, 8'h44, 32'hDEADBEEF, 4'd2},  // R2 word write
        '{1'b1, 2'd1, 8'h04, 32'h00000200, 2'd0, 8'h00, 32'h0,        4'd4},  // R4 size
        '{1'b1, 2'd1, 8'h06, 32'h00000003, 2'd0, 8'h00, 32'h0,        4'd4},  // R4 count
        '{1'b1, 2'd1, 8'h0C, 32'h00000011, 2'd0, 8'h00, 32'h0,        4'd5},  // R5
        '{1'b1, 2'd1, 8'h0E, 32'h00001234, 2'd2, 8'h0C, 32'h12340011, 4'd6},  // R6 flush both
        '{1'b1, 2'd1, 8'h0E, 32'h00005678, 2'd1, 8'h0C, 32'h56780011, 4'd6},  // R6 block empty
        '{1'b0, 2'd2, 8'h04, 32'h0,        2'd0, 8'h00, 32'h00030200, 4'd6},  // R6 block word landed
        '{1'b0, 2'd1, 8'h0E, 32'h0,        2'd0, 8'h00, 32'h00005678, 4'd1},  // R1
        '{1'b0, 2'd2, 8'h30, 32'h0,        2'd0, 8'h00, 32'h4C3CAB1C, 4'd3},  // R3 readback
        '{1'b1, 2'd0, 8'h44, 32'h00000077, 2'd1, 8'h44, 32'hDEADBE77, 4'd3}   // R3 lane 0
    };

    initial begin
        logic [31:0] rdat;
        int lat, ticks, nw, b;
        string tag;
        repeat (3) @(negedge clk);
        // R9: reset state
        chk("R9 ready", {31'd0, up_ready}, 32'd1);
        chk("R9 strobes", {29'd0, rd_valid, dn_rd, dn_wr}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        set_rate(32'd50_000_000);

        // R9: shadows start at zero, so a lone command write sends one word
        b = nwr;
        do_op(1'b1, 2'd1, 8'h0E, 32'h0001, rdat, lat, ticks, nw);
        chk("R9 shadow reset write count", 32'(nw), 32'd1);
        chk("R9 shadow reset data", log_d[b % 16], 32'h00010000);
        chk("R9 shadow reset addr", {24'd0, log_a[b % 16]}, 32'h0C);

        for (int v = 0; v < NV; v++) begin
            b = nwr;
            tag = $sformatf("R%0d vec%0d", VEC[v].rq, v);
            do_op(VEC[v].we, VEC[v].sz, VEC[v].addr, VEC[v].data, rdat, lat, ticks, nw);
            if (!VEC[v].we) begin
                chk({tag, " data"}, rdat, VEC[v].eval);
                chk({tag, " latency R1"}, 32'(lat), 32'd2);
            end else begin
                chk({tag, " writes"}, 32'(nw), 32'(VEC[v].nw));
                if (nw > 0) begin
                    chk({tag, " addr"}, {24'd0, log_a[(nwr - 1) % 16]}, {24'd0, VEC[v].eaddr});
                    chk({tag, " data"}, log_d[(nwr - 1) % 16], VEC[v].eval);
                end
                if (nw == 2) begin
                    chk({tag, " R6 block addr"}, {24'd0, log_a[b % 16]}, 32'h04);
                    chk({tag, " R6 block data"}, log_d[b % 16], 32'h00030200);
                end
            end
        end

        // R8: stopped clock holds for ten ticks
        set_rate(32'd0);
        do_op(1'b1, 2'd2, 8'h50, 32'h01020304, rdat, lat, ticks, nw);
        chk("R8 zero rate ticks", 32'(ticks), 32'd10);

        // R10: rate change drops ready while the divider runs
        card_clk_hz = 32'd100_000;
        #1;
        chk("R10 ready low during recompute", {31'd0, up_ready}, 32'd0);
        set_rate(32'd100_000);
        do_op(1'b1, 2'd2, 8'h50, 32'h0, rdat, lat, ticks, nw);
        chk("R8 100kHz ticks", 32'(ticks), 32'd40);

        set_rate(32'd300_000);
        do_op(1'b1, 2'd2, 8'h54, 32'h0, rdat, lat, ticks, nw);
        chk("R8 300kHz ticks", 32'(ticks), 32'd14);

        set_rate(32'd400_000);
        do_op(1'b1, 2'd2, 8'h54, 32'h0, rdat, lat, ticks, nw);
        chk("R8 400kHz ticks", 32'(ticks), 32'd10);

        set_rate(32'd400_001);
        do_op(1'b1, 2'd2, 8'h58, 32'h0, rdat, lat, ticks, nw);
        chk("R8 fast rate ticks", 32'(ticks), 32'd0);

        // R6 with hold-off between the two flushed words
        set_rate(32'd0);
        do_op(1'b1, 2'd1, 8'h04, 32'h0040, rdat, lat, ticks, nw);
        chk("R4 held with slow clock", 32'(nw), 32'd0);
        b = nwr;
        do_op(1'b1, 2'd1, 8'h0E, 32'h0099, rdat, lat, ticks, nw);
        chk("R6 two writes", 32'(nw), 32'd2);
        chk("R6 first addr", {24'd0, log_a[b % 16]}, 32'h04);
        chk("R6 first data", log_d[b % 16], 32'h00000040);
        chk("R6 second data", log_d[(b + 1) % 16], 32'h00990011);
        chk("R8 two holds ticks", 32'(ticks), 32'd20);

        // R10: no strobe while ready is high after all work
        @(negedge clk);
        chk("R10 idle strobes", {30'd0, dn_rd, dn_wr}, 32'd0);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule